// File: doc/BRIEF.md
# Two-Input Edge-Stepped Up Counter

This block is a four-bit synchronous up counter with two control inputs that can swap roles. The count value steps by one when the count input rises while the enable input is high. It also steps by one when the enable input falls while the count input is low. This lets a chain of stages be linked through either input, using whichever edge sense the previous stage provides. A parameter chooses between a decimal sequence (0 to 9) and a full four-bit sequence (0 to 15).

Both control inputs are slow, asynchronous levels. They pass through synchronizers in the system clock domain, and edges are found by comparing the newest sample with the one before it. The level of the other input is also taken from that earlier sample. An active-high clear takes effect at once and is released in step with the clock. A terminal-count flag marks the last code of the sequence, so a following stage or some control logic can watch for the carry.

Top module: `edge_step_counter`

## Requirements
- R1: While `rst_i` is high, `q_o` is 0 and `tc_o` is 0. The clear acts without waiting for a clock edge and takes priority over every other input.
- R2: A rising edge on `cnt_i` while `gate_i` is high adds one to `q_o`.
- R3: A falling edge on `gate_i` while `cnt_i` is low adds one to `q_o`.
- R4: A falling edge on `cnt_i` leaves `q_o` unchanged. A rising edge on `gate_i` also leaves `q_o` unchanged.
- R5: A rising edge on `cnt_i` while `gate_i` is low leaves `q_o` unchanged. A falling edge on `gate_i` while `cnt_i` is high also leaves `q_o` unchanged.
- R6: With `DECADE=1` (the default), the value after 9 is 0. A code from 10 to 15 moves to a code from 0 to 9 on its next step.
- R7: With `DECADE=0`, the value after 15 is 0.
- R8: With `SYNC_STAGES=2`, an input change made between clock edges shows up on `q_o` after the third rising `clk_i` edge that follows it, and not before. `q_o` changes only on a detected step, or when the clear acts.
- R9: A qualifying rising edge on `cnt_i` and a qualifying falling edge on `gate_i` that are detected in the same cycle add one to `q_o`, not two.
- R10: `tc_o` is high exactly when `q_o` is 9 with `DECADE=1`, or 15 with `DECADE=0`.
- R11: An edge whose detection falls while `rst_i` is high, or within `REL_STAGES` clock cycles after `rst_i` falls, is discarded, and `q_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples both control inputs |
| rst_i | input | 1 | Active-high clear; takes effect at once, released in step with `clk_i` |
| cnt_i | input | 1 | Count input; its rising edge steps the counter when enable is high |
| gate_i | input | 1 | Enable input; its falling edge steps the counter when count is low |
| q_o | output | 4 | Current count value |
| tc_o | output | 1 | High on the last code of the selected sequence |

## Verification
The two step sources can be detected in the same system clock cycle: a rising edge on the count input and a falling edge on the enable input. The bench provokes this by changing both inputs at the same moment, starting from count low and enable high. It then expects the value to grow by exactly one. The clear and a detected edge can also overlap. The bench launches an edge during reset, and another one cycle before release so that its detection lands in the release window. In both cases it expects the count to stay at zero.

// File: rtl/esc_pkg.sv
package esc_pkg;
    localparam int unsigned CNT_W   = 4;
    localparam int unsigned DEC_TOP = 9;
    localparam int unsigned BIN_TOP = (1 << CNT_W) - 1;

    typedef logic [CNT_W-1:0] cnt_t;

    // Last legal code of the selected sequence.
    function automatic cnt_t top_code(input bit decade);
        return decade ? cnt_t'(DEC_TOP) : cnt_t'(BIN_TOP);
    endfunction

    // Successor code. In decimal mode codes above the top fold into
    // the legal range in a single step by dropping the weight-8 bit.
    function automatic cnt_t succ(input cnt_t cur, input bit decade);
        cnt_t nxt;
        if (cur == top_code(decade)) begin
            nxt = '0;
        end else if (decade && (cur > cnt_t'(DEC_TOP))) begin
            nxt = {1'b0, cur[CNT_W-2:0]};
        end else begin
            nxt = cur + cnt_t'(1);
        end
        return nxt;
    endfunction
endpackage

// File: rtl/esc_sync.sv
module esc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/esc_edge.sv
module esc_edge (
    input  logic clk_i,
    input  logic cnt_s_i,
    input  logic gate_s_i,
    output logic cnt_p_o,
    output logic gate_p_o,
    output logic step_o
);
    typedef struct packed {
        logic cnt_p;
        logic gate_p;
    } hist_t;

    hist_t hist_d;
    hist_t hist_q;
    logic  cnt_rise_ok;
    logic  gate_fall_ok;

    always_comb begin
        hist_d.cnt_p  = cnt_s_i;
        hist_d.gate_p = gate_s_i;
        // The other input's level comes from the older sample.
        cnt_rise_ok  = cnt_s_i & ~hist_q.cnt_p & hist_q.gate_p;
        gate_fall_ok = ~gate_s_i & hist_q.gate_p & ~hist_q.cnt_p;
    end

    always_ff @(posedge clk_i) begin
        hist_q <= hist_d;
    end

    assign step_o   = cnt_rise_ok | gate_fall_ok;
    assign cnt_p_o  = hist_q.cnt_p;
    assign gate_p_o = hist_q.gate_p;
endmodule

// File: rtl/esc_core.sv
module esc_core
    import esc_pkg::*;
#(
    parameter bit          DECADE     = 1'b1,
    parameter int unsigned REL_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    output cnt_t q_o,
    output logic tc_o,
    output logic busy_o
);
    localparam cnt_t LAST = top_code(DECADE);

    typedef struct packed {
        logic [REL_STAGES-1:0] rel;
        cnt_t                  cnt;
    } core_t;

    core_t st_d;
    core_t st_q;

    always_comb begin
        st_d.rel = {st_q.rel[REL_STAGES-2:0], 1'b0};
        if (st_q.rel[REL_STAGES-1]) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            st_d.cnt = succ(st_q.cnt, DECADE);
        end else begin
            st_d.cnt = st_q.cnt;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q.rel <= '1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o    = st_q.cnt;
    assign tc_o   = (st_q.cnt == LAST);
    assign busy_o = st_q.rel[REL_STAGES-1];
endmodule

// File: rtl/edge_step_counter.sv
module edge_step_counter
    import esc_pkg::*;
#(
    parameter bit          DECADE      = 1'b1,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REL_STAGES  = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cnt_i,
    input  logic             gate_i,
    output logic [CNT_W-1:0] q_o,
    output logic             tc_o
);
    localparam int unsigned N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] syn_in;
    logic            cnt_sync;
    logic            gate_sync;
    logic            cnt_prev;
    logic            gate_prev;
    logic            step;
    logic            busy;

    assign raw_in = {gate_i, cnt_i};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
        esc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i (clk_i),
            .d_i   (raw_in[gi]),
            .q_o   (syn_in[gi])
        );
    end

    assign cnt_sync  = syn_in[0];
    assign gate_sync = syn_in[1];

    esc_edge u_edge (
        .clk_i    (clk_i),
        .cnt_s_i  (cnt_sync),
        .gate_s_i (gate_sync),
        .cnt_p_o  (cnt_prev),
        .gate_p_o (gate_prev),
        .step_o   (step)
    );

    esc_core #(
        .DECADE     (DECADE),
        .REL_STAGES (REL_STAGES)
    ) u_core (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .step_i (step),
        .q_o    (q_o),
        .tc_o   (tc_o),
        .busy_o (busy)
    );
endmodule

// File: rtl/esc_checker.sv
module esc_checker
    import esc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input logic clk_i,
    input logic rst_i,
    input logic busy_i,
    input logic step_i,
    input logic cnt_s_i,
    input logic cnt_p_i,
    input logic gate_s_i,
    input logic gate_p_i,
    input cnt_t q_i
);
    localparam cnt_t LAST = top_code(DECADE);

    // R8: no detected step, no change of value
    a_r8_hold_without_step: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(q_i));

    // R2/R3: an accepted step below the top code adds one
    a_r2_step_adds_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !busy_i && q_i < LAST) |=> (q_i == cnt_t'($past(q_i) + cnt_t'(1))));

    // R6/R7: an accepted step on the top code wraps to zero
    a_r6_wrap_to_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !busy_i && q_i == LAST) |=> (q_i == '0));

    // R6: codes above the top recover in one step
    a_r6_illegal_recovers: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !busy_i && q_i > LAST) |=> (q_i <= LAST));

    // R4: a falling count edge with a steady enable never steps
    a_r4_cnt_fall_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cnt_s_i && cnt_p_i && (gate_s_i == gate_p_i)) |-> !step_i);

    // R5: a rising count edge with enable low never steps
    a_r5_cnt_rise_blocked: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_s_i && !cnt_p_i && !gate_p_i) |-> !step_i);

    // R5: a falling enable edge with count high never steps
    a_r5_gate_fall_blocked: assert property (@(posedge clk_i) disable iff (rst_i)
        (!gate_s_i && gate_p_i && cnt_s_i && cnt_p_i) |-> !step_i);

    // R11: the release window forces the value to zero
    a_r11_release_holds_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i |=> (q_i == '0));
endmodule

bind edge_step_counter esc_checker #(.DECADE(DECADE)) u_esc_checker (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .busy_i   (busy),
    .step_i   (step),
    .cnt_s_i  (cnt_sync),
    .cnt_p_i  (cnt_prev),
    .gate_s_i (gate_sync),
    .gate_p_i (gate_prev),
    .q_i      (q_o)
);

// File: tb/test_edge_step_counter.sv
module test_edge_step_counter;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cnt;
    logic       gate;
    logic [3:0] q_dec;
    logic [3:0] q_bin;
    logic       tc_dec;
    logic       tc_bin;

    int errors = 0;
    int checks = 0;
    int exp_d  = 0;
    int exp_b  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edge_step_counter i_edge_step_counter (
        .clk_i (clk), .rst_i (rst), .cnt_i (cnt), .gate_i (gate),
        .q_o (q_dec), .tc_o (tc_dec)
    );

    edge_step_counter #(.DECADE(1'b0)) i_edge_step_counter_bin (
        .clk_i (clk), .rst_i (rst), .cnt_i (cnt), .gate_i (gate),
        .q_o (q_bin), .tc_o (tc_bin)
    );

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_both(input string req);
        check_val({req, " decimal"}, int'(q_dec), exp_d);
        check_val({req, " binary"}, int'(q_bin), exp_b);
    endtask

    task automatic bump();
        exp_d = (exp_d == 9) ? 0 : exp_d + 1;
        exp_b = (exp_b + 1) % 16;
    endtask

    task automatic apply(input logic c, input logic g);
        @(negedge clk);
        cnt  = c;
        gate = g;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse();
        apply(1'b1, 1'b1);
        bump();
        apply(1'b0, 1'b1);
    endtask

    task automatic t_reset_state();
        check_both("R1 reset value");
        check_val("R1 tc in reset", int'(tc_dec), 0);
    endtask

    task automatic t_count_rise();
        apply(1'b1, 1'b1);
        bump();
        check_both("R2 count rise, enable high");
        apply(1'b0, 1'b1);
        check_both("R4 count fall");
    endtask

    task automatic t_gate_fall();
        apply(1'b0, 1'b0);
        bump();
        check_both("R3 enable fall, count low");
        apply(1'b0, 1'b1);
        check_both("R4 enable rise");
    endtask

    task automatic t_blocked();
        apply(1'b1, 1'b1);
        bump();
        check_both("R2 count rise before blocked cases");
        apply(1'b1, 1'b0);
        check_both("R5 enable fall, count high");
        apply(1'b0, 1'b0);
        check_both("R4 count fall, enable low");
        apply(1'b1, 1'b0);
        check_both("R5 count rise, enable low");
        apply(1'b1, 1'b1);
        check_both("R4 enable rise, count high");
        apply(1'b0, 1'b1);
        check_both("R4 count fall, enable high");
    endtask

    task automatic t_latency();
        @(negedge clk);
        cnt  = 1'b1;
        gate = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_both("R8 unchanged after two edges");
        @(posedge clk);
        @(negedge clk);
        bump();
        check_both("R8 updated after third edge");
        apply(1'b0, 1'b1);
    endtask

    task automatic t_coincident();
        apply(1'b1, 1'b0);
        bump();
        check_both("R9 coincident edges step once");
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1);
        check_both("R9 value after restoring inputs");
    endtask

    task automatic t_wrap();
        while (exp_d != 9) pulse();
        check_val("R10 decimal tc at 9", int'(tc_dec), 1);
        pulse();
        check_both("R6 decimal wrap 9 to 0");
        check_val("R10 decimal tc after wrap", int'(tc_dec), 0);
        while (exp_b != 15) pulse();
        check_val("R10 binary tc at 15", int'(tc_bin), 1);
        check_val("R10 decimal tc not at top", int'(tc_dec), (exp_d == 9) ? 1 : 0);
        pulse();
        check_both("R7 binary wrap 15 to 0");
        check_val("R10 binary tc after wrap", int'(tc_bin), 0);
    endtask

    task automatic t_reset_overlap();
        pulse();
        check_both("R2 nonzero before clear");
        @(negedge clk);
        rst = 1'b1;
        #1;
        exp_d = 0;
        exp_b = 0;
        check_both("R1 clear acts without clock");
        @(negedge clk);
        cnt = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_both("R11 edge during reset discarded");
        apply(1'b0, 1'b1);
        @(negedge clk);
        cnt = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_both("R11 edge in release window discarded");
        apply(1'b0, 1'b1);
        apply(1'b1, 1'b1);
        bump();
        check_both("R2 counting resumes after release");
        apply(1'b0, 1'b1);
    endtask

    initial begin
        rst  = 1'b1;
        cnt  = 1'b0;
        gate = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_count_rise();
        t_gate_fall();
        t_blocked();
        t_latency();
        t_coincident();
        t_wrap();
        t_reset_overlap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule